// File: doc/BRIEF.md
# Tile Background Scanline Renderer

This block produces the background pixels of one display line for a tile-mapped screen. On a start pulse it captures the line number, the vertical scroll amount and the name-table bank select, then walks the visible tile columns from left to right. For each column it reads a 16-bit name entry from video memory. It then reads the four bitplane bytes of the selected tile row. Each pixel is decoded into a colour index, which is looked up in colour memory and expanded from 12 to 24 bits.

Both memories are reached through plain synchronous read ports. A read strobe with an address in one cycle returns the byte in the next cycle. Pixels leave on a valid/ready stream that carries the x coordinate and the RGB value. Back-pressure rules: once `pix_valid` is high, it stays high and `pix_x`/`pix_rgb` stay unchanged until a cycle with `pix_ready` high. A pixel is transferred on the rising edge where both are high. `pix_valid` does not depend combinationally on `pix_ready`. When the last pixel of the line has been accepted, the block raises `done` for one cycle and returns to idle.

Top module: `bgr_line_render`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `busy`, `done`, `pix_valid`, `vram_rd` and `cram_rd` are all 0. A reset in the middle of a line returns the block to this idle state.
- R2: `start` is accepted only when idle. `busy` is 1 from the cycle after acceptance until the line ends. A `start` pulse or changed `line_num`/`vscroll`/`nt_sel` during a line has no effect on that line's pixels.
- R3: The name entry for column c is read from video address nt_sel*2048 + (row/8)*64 + 2*c. The low byte is at that even address and the high byte at the next address.
- R4: The tile row is (line_num + vscroll) mod 224, with both inputs taken as unsigned 8-bit values.
- R5: Only columns 6 to 25 are drawn. The line yields exactly 160 pixels, with x running from 48 to 207 in increasing order, where x = 8*column + pixel slot.
- R6: In the name entry, bits 8:0 are the pattern number, bit 9 is horizontal mirror, bit 10 is vertical mirror and bit 11 is palette select. The four plane bytes of a row are at pattern*32 + 4*r + plane, where r = row mod 8, or 7 - (row mod 8) when vertically mirrored.
- R7: For the pixel at slot p of a tile, bit i of planes 0..3 gives bits 0..3 of the colour index. i = p normally and i = 7 - p when horizontally mirrored.
- R8: The colour word sits at colour address 2*(index + 16*palette_select) (low byte) and the next address (high byte).
- R9: Red is low byte bits 3:0, green is low byte bits 7:4 and blue is high byte bits 3:0. Each 4-bit value n becomes n*0x11. `pix_rgb` is {red, green, blue} with red in bits 23:16.
- R10: While `pix_valid` is high and `pix_ready` is low, the next cycle still shows `pix_valid` with the same `pix_x` and `pix_rgb`.
- R11: `done` is high for exactly one cycle, directly after the transfer of the pixel at x = 207. In the following cycle `busy` is 0.
- R12: Read data is taken from `vram_data`/`cram_data` in the cycle after the matching read strobe. The two memories are never read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a line; inputs below are captured |
| line_num | input | 8 | Display line number |
| vscroll | input | 8 | Vertical scroll amount |
| nt_sel | input | 3 | Name-table bank (2 KiB units) |
| busy | output | 1 | A line is in progress |
| done | output | 1 | One-cycle end-of-line pulse |
| vram_rd | output | 1 | Video memory read strobe |
| vram_addr | output | 14 | Video memory byte address |
| vram_data | input | 8 | Video memory data, one cycle after strobe |
| cram_rd | output | 1 | Colour memory read strobe |
| cram_addr | output | 6 | Colour memory byte address |
| cram_data | input | 8 | Colour memory data, one cycle after strobe |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Sink accepts pixel |
| pix_x | output | 8 | Pixel x coordinate |
| pix_rgb | output | 24 | Pixel colour, 8 bits per channel |

## Verification
Two events can coincide. A new `start`, together with changed line, scroll and bank inputs, may arrive in the same cycle in which the stream is stalled or a pixel is being handed over. One vector raises `start` with altered inputs just after the fiftieth pixel is accepted, while the sink follows a repeating stall pattern. The check is that every remaining pixel still equals the value computed from the originally captured inputs. A second coincidence is back-pressure against the end of the line. There the final transfer must still be followed by exactly one `done` cycle, and held pixels must not change during any stall.

// File: rtl/bgr_pkg.sv
package bgr_pkg;
  localparam int TILE_PX = 8;
  localparam int NPLANES = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_NLO, ST_NHI, ST_NWAIT, ST_PLANE, ST_PWAIT,
    ST_CLO, ST_CHI, ST_CWAIT, ST_EMIT, ST_DONE
  } rstate_t;

  typedef enum logic [1:0] {VT_NONE, VT_NLO, VT_NHI, VT_PLANE} vtag_t;
  typedef enum logic [1:0] {CT_NONE, CT_LO, CT_HI} ctag_t;
endpackage

// File: rtl/bgr_addr_gen.sv
module bgr_addr_gen #(
  parameter int VA_W     = 14,
  parameter int NT_W     = 3,
  parameter int COL_W    = 5,
  parameter int ROW_WRAP = 224
) (
  input  logic [7:0]       line_num,
  input  logic [7:0]       vscroll,
  input  logic [NT_W-1:0]  nt_sel,
  input  logic [COL_W-1:0] col,
  input  logic [15:0]      entry,
  output logic [VA_W-1:0]  name_addr,
  output logic [VA_W-1:0]  pat_addr
);
  localparam logic [8:0] WRAP1 = 9'(ROW_WRAP);
  localparam logic [8:0] WRAP2 = 9'(2 * ROW_WRAP);

  logic [8:0] sum;
  logic [8:0] row9;
  logic [7:0] row;
  logic [2:0] fine_y;

  always_comb begin
    sum = {1'b0, line_num} + {1'b0, vscroll};
    if (sum >= WRAP2)      row9 = sum - WRAP2;
    else if (sum >= WRAP1) row9 = sum - WRAP1;
    else                   row9 = sum;
    row = row9[7:0];
  end

  // vertical mirror picks the opposite row inside the tile
  assign fine_y    = entry[10] ? ~row[2:0] : row[2:0];
  assign name_addr = VA_W'({nt_sel, row[7:3], col, 1'b0});
  assign pat_addr  = VA_W'({entry[8:0], fine_y, 2'b00});

  always_comb begin
    assert_row_wrap_R4: assert (int'(row9) < ROW_WRAP)
      else $error("tile row out of range");
  end
endmodule

// File: rtl/bgr_pix_decode.sv
module bgr_pix_decode
  import bgr_pkg::*;
#(
  parameter int CA_W = 6
) (
  input  logic [NPLANES-1:0][7:0] planes,
  input  logic [2:0]              slot,
  input  logic                    hmirror,
  input  logic                    pal,
  output logic [CA_W-1:0]         cram_base
);
  logic [2:0]         bsel;
  logic [NPLANES-1:0] idx;

  assign bsel = hmirror ? ~slot : slot;

  for (genvar k = 0; k < NPLANES; k++) begin : g_plane
    assign idx[k] = planes[k][bsel];
  end

  assign cram_base = CA_W'({pal, idx, 1'b0});
endmodule

// File: rtl/bgr_color_expand.sv
module bgr_color_expand (
  input  logic [7:0]  lo,
  input  logic [7:0]  hi,
  output logic [23:0] rgb
);
  logic [2:0][3:0] nib;

  assign nib[0] = lo[3:0];
  assign nib[1] = lo[7:4];
  assign nib[2] = hi[3:0];

  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign rgb[23-8*c -: 8] = {nib[c], nib[c]};
  end
endmodule

// File: rtl/bgr_line_render.sv
module bgr_line_render
  import bgr_pkg::*;
#(
  parameter int COL_FIRST = 6,
  parameter int COL_LAST  = 25,
  parameter int ROW_WRAP  = 224,
  parameter int VA_W      = 14,
  parameter int CA_W      = 6,
  parameter int NT_W      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      line_num,
  input  logic [7:0]      vscroll,
  input  logic [NT_W-1:0] nt_sel,
  output logic            busy,
  output logic            done,
  output logic            vram_rd,
  output logic [VA_W-1:0] vram_addr,
  input  logic [7:0]      vram_data,
  output logic            cram_rd,
  output logic [CA_W-1:0] cram_addr,
  input  logic [7:0]      cram_data,
  output logic            pix_valid,
  input  logic            pix_ready,
  output logic [7:0]      pix_x,
  output logic [23:0]     pix_rgb
);
  localparam int COL_W   = 5;
  localparam int PX_W    = $clog2(TILE_PX);
  localparam int PL_W    = $clog2(NPLANES);
  localparam int X_FIRST = COL_FIRST * TILE_PX;
  localparam int X_LAST  = COL_LAST * TILE_PX + TILE_PX - 1;

  rstate_t                 st;
  vtag_t                   vtag;
  ctag_t                   ctag;
  logic [PL_W-1:0]         vtag_pl;
  logic [7:0]              lat_line, lat_vs;
  logic [NT_W-1:0]         lat_nt;
  logic [COL_W-1:0]        col;
  logic [PX_W-1:0]         px;
  logic [PL_W-1:0]         pl_cnt;
  logic [15:0]             entry;
  logic [NPLANES-1:0][7:0] planes;
  logic [7:0]              clr_lo, clr_hi;

  logic [VA_W-1:0] name_addr, pat_addr;
  logic [CA_W-1:0] cram_base;

  bgr_addr_gen #(.VA_W(VA_W), .NT_W(NT_W), .COL_W(COL_W), .ROW_WRAP(ROW_WRAP)) u_addr (
    .line_num (lat_line),
    .vscroll  (lat_vs),
    .nt_sel   (lat_nt),
    .col      (col),
    .entry    (entry),
    .name_addr(name_addr),
    .pat_addr (pat_addr)
  );

  bgr_pix_decode #(.CA_W(CA_W)) u_dec (
    .planes   (planes),
    .slot     (px),
    .hmirror  (entry[9]),
    .pal      (entry[11]),
    .cram_base(cram_base)
  );

  bgr_color_expand u_clr (
    .lo (clr_lo),
    .hi (clr_hi),
    .rgb(pix_rgb)
  );

  // read port drive, one read per cycle at most
  always_comb begin
    vram_rd   = 1'b0;
    vram_addr = name_addr;
    cram_rd   = 1'b0;
    cram_addr = cram_base;
    unique case (st)
      ST_NLO:   vram_rd = 1'b1;
      ST_NHI:   begin vram_rd = 1'b1; vram_addr = name_addr + VA_W'(1); end
      ST_PLANE: begin vram_rd = 1'b1; vram_addr = pat_addr + VA_W'(pl_cnt); end
      ST_CLO:   cram_rd = 1'b1;
      ST_CHI:   begin cram_rd = 1'b1; cram_addr = cram_base + CA_W'(1); end
      default:  ;
    endcase
  end

  assign pix_valid = (st == ST_EMIT);
  assign pix_x     = 8'({col, px});
  assign done      = (st == ST_DONE);
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      vtag     <= VT_NONE;
      ctag     <= CT_NONE;
      vtag_pl  <= '0;
      lat_line <= '0;
      lat_vs   <= '0;
      lat_nt   <= '0;
      col      <= '0;
      px       <= '0;
      pl_cnt   <= '0;
      entry    <= '0;
      planes   <= '0;
      clr_lo   <= '0;
      clr_hi   <= '0;
    end else begin
      // capture data requested in the previous cycle
      unique case (vtag)
        VT_NLO:   entry[7:0]      <= vram_data;
        VT_NHI:   entry[15:8]     <= vram_data;
        VT_PLANE: planes[vtag_pl] <= vram_data;
        default:  ;
      endcase
      unique case (ctag)
        CT_LO:   clr_lo <= cram_data;
        CT_HI:   clr_hi <= cram_data;
        default: ;
      endcase
      vtag <= VT_NONE;
      ctag <= CT_NONE;

      unique case (st)
        ST_IDLE: if (start) begin
          lat_line <= line_num;
          lat_vs   <= vscroll;
          lat_nt   <= nt_sel;
          col      <= COL_W'(COL_FIRST);
          st       <= ST_NLO;
        end
        ST_NLO:   begin vtag <= VT_NLO; st <= ST_NHI; end
        ST_NHI:   begin vtag <= VT_NHI; st <= ST_NWAIT; end
        ST_NWAIT: begin pl_cnt <= '0; st <= ST_PLANE; end
        ST_PLANE: begin
          vtag    <= VT_PLANE;
          vtag_pl <= pl_cnt;
          pl_cnt  <= pl_cnt + PL_W'(1);
          if (pl_cnt == PL_W'(NPLANES - 1)) st <= ST_PWAIT;
        end
        ST_PWAIT: begin px <= '0; st <= ST_CLO; end
        ST_CLO:   begin ctag <= CT_LO; st <= ST_CHI; end
        ST_CHI:   begin ctag <= CT_HI; st <= ST_CWAIT; end
        ST_CWAIT: st <= ST_EMIT;
        ST_EMIT: if (pix_ready) begin
          if (px == PX_W'(TILE_PX - 1)) begin
            if (col == COL_W'(COL_LAST)) st <= ST_DONE;
            else begin
              col <= col + COL_W'(1);
              st  <= ST_NLO;
            end
          end else begin
            px <= px + PX_W'(1);
            st <= ST_CLO;
          end
        end
        ST_DONE:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_rgb)));

  assert_x_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (int'(pix_x) >= X_FIRST && int'(pix_x) <= X_LAST));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_done_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pix_valid && pix_ready && int'(pix_x) == X_LAST));

  assert_one_port_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(vram_rd && cram_rd));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!vram_rd && !cram_rd && !pix_valid && !done));
endmodule

// File: tb/tb_bgr_line_render.sv
`timescale 1ns/1ps
module tb_bgr_line_render;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  line_num = '0;
  logic [7:0]  vscroll = '0;
  logic [2:0]  nt_sel = '0;
  logic        busy, done, vram_rd, cram_rd, pix_valid;
  logic        pix_ready = 1'b0;
  logic [13:0] vram_addr;
  logic [5:0]  cram_addr;
  logic [7:0]  vram_data = '0;
  logic [7:0]  cram_data = '0;
  logic [7:0]  pix_x;
  logic [23:0] pix_rgb;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  int salt_g = 0;

  always #2.5 clk = ~clk;

  bgr_line_render dut (
    .clk(clk), .rst_n(rst_n), .start(start), .line_num(line_num),
    .vscroll(vscroll), .nt_sel(nt_sel), .busy(busy), .done(done),
    .vram_rd(vram_rd), .vram_addr(vram_addr), .vram_data(vram_data),
    .cram_rd(cram_rd), .cram_addr(cram_addr), .cram_data(cram_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x), .pix_rgb(pix_rgb)
  );

  // memory contents are computed from the address, no storage needed
  function automatic logic [7:0] vf(int a);
    logic [31:0] h;
    h = 32'(a) * 32'd40503 + 32'(salt_g) * 32'd7919 + 32'd12345;
    return h[15:8] ^ h[23:16];
  endfunction

  function automatic logic [7:0] cf(int a);
    logic [31:0] h;
    h = 32'(a) * 32'd73 + 32'(salt_g) * 32'd29 + 32'd5;
    return h[7:0];
  endfunction

  always @(posedge clk) begin
    if (vram_rd) vram_data <= vf(int'(vram_addr));
    if (cram_rd) cram_data <= cf(int'(cram_addr));
  end

  function automatic logic [23:0] exp_rgb(int x, int l, int s, int nt);
    int col, p, row, na, e, pat, hf, vm, pal, r, i, idx, ca, lo, hi;
    col = x / 8; p = x % 8;
    row = (l + s) % 224;
    na  = nt * 2048 + (row / 8) * 64 + col * 2;
    e   = int'(vf(na)) + int'(vf(na + 1)) * 256;
    pat = e % 512; hf = (e / 512) % 2; vm = (e / 1024) % 2; pal = (e / 2048) % 2;
    r   = row % 8;
    if (vm != 0) r = 7 - r;
    i   = (hf != 0) ? 7 - p : p;
    idx = 0;
    for (int k = 0; k < 4; k++) idx += ((int'(vf(pat * 32 + 4 * r + k)) >> i) & 1) << k;
    ca  = 2 * (idx + 16 * pal);
    lo  = int'(cf(ca)); hi = int'(cf(ca + 1));
    return {8'((lo % 16) * 17), 8'((lo / 16) * 17), 8'((hi % 16) * 17)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // fields: line, scroll, bank, salt, mode (bit0 stall pattern, bit1 mid-line start)
  localparam logic [39:0] VEC [0:6] = '{
    {8'd0,   8'd0,   8'd0, 8'd1, 8'd0},
    {8'd100, 8'd50,  8'd3, 8'd2, 8'd1},
    {8'd200, 8'd24,  8'd7, 8'd3, 8'd0},
    {8'd255, 8'd255, 8'd5, 8'd4, 8'd1},
    {8'd223, 8'd0,   8'd1, 8'd5, 8'd2},
    {8'd150, 8'd200, 8'd2, 8'd6, 8'd3},
    {8'd10,  8'd220, 8'd6, 8'd7, 8'd0}
  };

  task automatic run_line(input logic [39:0] vv);
    int l, s, nt, md, n, t, mism;
    bit stall_pend;
    logic [7:0] sx;
    logic [23:0] srgb, e;
    l = int'(vv[39:32]); s = int'(vv[31:24]); nt = int'(vv[23:16]);
    salt_g = int'(vv[15:8]); md = int'(vv[7:0]);
    line_num = 8'(l); vscroll = 8'(s); nt_sel = 3'(nt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
    n = 0; t = 0; mism = 0; stall_pend = 0; sx = '0; srgb = '0;
    while (n < 160 && t < 6000) begin
      if (start) start = 1'b0;
      pix_ready = md[0] ? ((t % 3) != 0) : 1'b1;
      if (stall_pend) begin
        chk(pix_valid && pix_x == sx && pix_rgb == srgb, "R10 pixel held during stall",
            {pix_x, pix_rgb}, {sx, srgb});
        stall_pend = 0;
      end
      if (pix_valid) begin
        if (!pix_ready) begin
          stall_pend = 1; sx = pix_x; srgb = pix_rgb;
        end else begin
          chk(pix_x == 8'(48 + n), "R5 pixel x order", 32'(pix_x), 32'(48 + n));
          e = exp_rgb(48 + n, l, s, nt);
          if (pix_rgb != e) mism++;
          chk(pix_rgb == e, "R3 R4 R6 R7 R8 R9 R12 pixel colour", 32'(pix_rgb), 32'(e));
          n++;
          if (md[1] && n == 50) begin
            start = 1'b1;
            line_num = 8'(l + 77); vscroll = 8'(s + 13); nt_sel = 3'(nt + 1);
          end
        end
      end
      t++;
      @(negedge clk);
    end
    start = 1'b0;
    if (t >= 6000) chk(1'b0, "R11 watchdog line did not finish", 32'(n), 160);
    chk(n == 160, "R5 pixel count", 32'(n), 160);
    chk(done == 1'b1, "R11 done after last pixel", 32'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11 done one cycle then idle", {done, busy}, 0);
    if (md[1]) chk(mism == 0, "R2 start during line ignored", 32'(mism), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk({busy, done, pix_valid, vram_rd, cram_rd} == 5'b0, "R1 outputs in reset",
        32'({busy, done, pix_valid, vram_rd, cram_rd}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, done, pix_valid, vram_rd, cram_rd} == 5'b0, "R1 idle after reset",
        32'({busy, done, pix_valid, vram_rd, cram_rd}), 0);

    for (int v = 0; v < 7; v++) run_line(VEC[v]);

    // reset in the middle of a line
    salt_g = 9; line_num = 8'd40; vscroll = 8'd3; nt_sel = 3'd4; pix_ready = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({busy, done, pix_valid, vram_rd, cram_rd} == 5'b0, "R1 mid-line reset",
        32'({busy, done, pix_valid, vram_rd, cram_rd}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_line(VEC[2]);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule